// File: doc/BRIEF.md
# SATA Host Port Control and Status Registers

This block holds the software-visible registers of one host port in a SATA host controller. A 32-bit register bus reaches it: an address, write data, a write enable and a read-data return. It stores the command-list and receive-area base addresses. It also keeps the interrupt status and enable words, the port command word, the link control, error, active and command-issue words, and it shows the task-file, signature and link status values that other logic supplies.

A write to the command word may start or stop the command-list engine and the receive engine. Each engine runs only if its address-valid input is true. The block reports the running state in two read-only command bits. The first time the receive engine starts, it asks once for the initial device-to-host status frame. When the detect field of the link control word falls from 1 to 0, it resets the port. A write to the command-issue word raises a strobe for the command scheduler. The interrupt line is the reduction of the status bits that are enabled.

Top module: `hport_csr`

## Requirements
- R1: After `rst`, every register reads zero, and `irq`, `port_rst`, `init_req`, `issue_stb` and `eng_err` are low.
- R2: The list base words (0x00, 0x04) and receive base words (0x08, 0x0C) store all 32 written bits and read them back.
- R3: Interrupt status (0x10) gains every bit that is high on `irq_set`. A write clears the status bits written as 1. A bit set by `irq_set` in the same cycle as a clearing write stays set.
- R4: Interrupt enable (0x14) stores the written data ANDed with 0xFDC000FF. `irq` is high exactly when status AND enable is non-zero, and it follows the same edge that changes either word.
- R5: A write to the command word (0x18) stores every bit except bits 15 and 14. Those two bits take nothing from the written data.
- R6: On a command write with bit 0 (start) set, bit 15 (list running) is set if `list_ok` is high. If `list_ok` is low, bit 15 is not set and `eng_err` pulses for one cycle. A command write with bit 0 clear clears bit 15.
- R7: Bit 4 (receive enable) controls bit 14 (receive running) by the same rule, using `rx_ok`. A failure also pulses `eng_err`.
- R8: `init_req` pulses for one cycle the first time bit 14 is set after `rst`. It never pulses again until the next `rst`.
- R9: A write to link control (0x2C) that changes bits 3:0 (detect) from 1 to 0 stores the new value and pulses `port_rst` for one cycle. The same write clears interrupt status, link error, link active, command issue and command bits 15 and 14. A detect value other than 1 before the write causes no reset.
- R10: Link error (0x30) gains bits from `lerr_set` and clears the bits written as 1. Link active (0x34) and command issue (0x38) set the bits written as 1. A command-issue write pulses `issue_stb` for one cycle.
- R11: Task-file (0x20), signature (0x24) and link status (0x28) read `tfd_in`, `sig_in` and `ssts_in` and ignore writes. Undefined offsets read zero.
- R12: `rdata` is registered. It shows the word selected by `addr` in the cycle before the edge, as the registers held it before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 6 | Byte offset of the register |
| wdata | input | 32 | Write data |
| we | input | 1 | Write enable |
| rdata | output | 32 | Registered read data |
| list_ok | input | 1 | Command-list base address is usable |
| rx_ok | input | 1 | Receive-area base address is usable |
| irq_set | input | 32 | Interrupt events to latch into status |
| lerr_set | input | 32 | Link error events to latch |
| tfd_in | input | 32 | Task-file value to show |
| sig_in | input | 32 | Device signature to show |
| ssts_in | input | 32 | Link status to show |
| irq | output | 1 | Port interrupt |
| port_rst | output | 1 | One-cycle port reset pulse |
| init_req | output | 1 | One-shot initial status frame request |
| issue_stb | output | 1 | Command issue was written |
| eng_err | output | 1 | An engine start was refused |

## Verification
Every register write takes effect at the edge that samples `we`. The pulses `port_rst`, `init_req`, `issue_stb` and `eng_err`, and the new `irq` level, appear in the cycle after that edge. The bench drives inputs on the falling edge and samples the pulse outputs on the next falling edge, so it reads them in exactly the one cycle they are high. A read presents the offset for one edge and samples `rdata` half a cycle later. Because of that, a write and a read of the same word never share an edge. One check confirms that a read during a write returns the old value.

// File: rtl/hport_pkg.sv
package hport_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_LBL = 6'h00;
  localparam logic [ADDR_W-1:0] A_LBH = 6'h04;
  localparam logic [ADDR_W-1:0] A_RBL = 6'h08;
  localparam logic [ADDR_W-1:0] A_RBH = 6'h0C;
  localparam logic [ADDR_W-1:0] A_ISR = 6'h10;
  localparam logic [ADDR_W-1:0] A_IEN = 6'h14;
  localparam logic [ADDR_W-1:0] A_CMD = 6'h18;
  localparam logic [ADDR_W-1:0] A_TFD = 6'h20;
  localparam logic [ADDR_W-1:0] A_SIG = 6'h24;
  localparam logic [ADDR_W-1:0] A_LST = 6'h28;
  localparam logic [ADDR_W-1:0] A_LCT = 6'h2C;
  localparam logic [ADDR_W-1:0] A_LER = 6'h30;
  localparam logic [ADDR_W-1:0] A_LAC = 6'h34;
  localparam logic [ADDR_W-1:0] A_ISS = 6'h38;

  localparam int CMD_START = 0;
  localparam int CMD_RXEN  = 4;
  localparam int CMD_RXRUN = 14;
  localparam int CMD_LRUN  = 15;

  localparam int N_ENG = 2;
  localparam int DET_W = 4;
endpackage

// File: rtl/hport_eng_ctl.sv
module hport_eng_ctl (
  input  logic en,
  input  logic run_q,
  input  logic addr_ok,
  output logic run_d,
  output logic fail
);
  always_comb begin
    run_d = run_q;
    fail  = 1'b0;
    if (en) begin
      if (addr_ok) run_d = 1'b1;
      else         fail  = 1'b1;
    end else begin
      run_d = 1'b0;
    end
  end
endmodule

// File: rtl/hport_irq.sv
module hport_irq #(
  parameter int          DW      = 32,
  parameter logic [31:0] IE_MASK = 32'hFDC0_00FF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_is,
  input  logic          wr_ie,
  input  logic          clr_all,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] hw_set,
  output logic [DW-1:0] is_q,
  output logic [DW-1:0] ie_q,
  output logic          irq
);
  localparam logic [DW-1:0] MASK = DW'(IE_MASK);
  logic [DW-1:0] is_n, ie_n;

  always_comb begin
    if (clr_all) is_n = '0;
    else         is_n = (wr_is ? (is_q & ~wdata) : is_q) | hw_set;
    ie_n = wr_ie ? (wdata & MASK) : ie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      is_q <= '0;
      ie_q <= '0;
      irq  <= 1'b0;
    end else begin
      is_q <= is_n;
      ie_q <= ie_n;
      irq  <= |(is_n & ie_n);
    end
  end
endmodule

// File: rtl/hport_link.sv
module hport_link #(
  parameter int DW    = 32,
  parameter int DET_W = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ctl,
  input  logic          wr_err,
  input  logic          wr_act,
  input  logic          wr_iss,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] err_set,
  output logic [DW-1:0] ctl_q,
  output logic [DW-1:0] err_q,
  output logic [DW-1:0] act_q,
  output logic [DW-1:0] iss_q,
  output logic          prst_now,
  output logic          port_rst,
  output logic          iss_stb
);
  assign prst_now = wr_ctl && (ctl_q[DET_W-1:0] == DET_W'(1))
                           && (wdata[DET_W-1:0] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q    <= '0;
      err_q    <= '0;
      act_q    <= '0;
      iss_q    <= '0;
      port_rst <= 1'b0;
      iss_stb  <= 1'b0;
    end else begin
      port_rst <= prst_now;
      iss_stb  <= wr_iss;
      if (wr_ctl) ctl_q <= wdata;
      if (prst_now) begin
        err_q <= '0;
        act_q <= '0;
        iss_q <= '0;
      end else begin
        err_q <= (wr_err ? (err_q & ~wdata) : err_q) | err_set;
        if (wr_act) act_q <= act_q | wdata;
        if (wr_iss) iss_q <= iss_q | wdata;
      end
    end
  end
endmodule

// File: rtl/hport_csr.sv
module hport_csr
  import hport_pkg::*;
#(
  parameter int          AW      = ADDR_W,
  parameter int          DW      = DATA_W,
  parameter logic [31:0] IE_MASK = 32'hFDC0_00FF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          we,
  output logic [DW-1:0] rdata,
  input  logic          list_ok,
  input  logic          rx_ok,
  input  logic [DW-1:0] irq_set,
  input  logic [DW-1:0] lerr_set,
  input  logic [DW-1:0] tfd_in,
  input  logic [DW-1:0] sig_in,
  input  logic [DW-1:0] ssts_in,
  output logic          irq,
  output logic          port_rst,
  output logic          init_req,
  output logic          issue_stb,
  output logic          eng_err
);
  localparam logic [DW-1:0] RO_MASK = (DW'(1) << CMD_LRUN) | (DW'(1) << CMD_RXRUN);

  logic [DW-1:0] lbl_q, lbh_q, rbl_q, rbh_q, cmd_q, cmd_w, merged;
  logic [DW-1:0] is_q, ie_q, ctl_q, err_q, act_q, ci_q, rd_mux;
  logic          sent_q, prst_now, wr_cmd;
  logic [N_ENG-1:0] eng_en, eng_run_q, eng_ok, eng_run_d, eng_fail;

  function automatic logic hit(input logic [AW-1:0] a, input logic [ADDR_W-1:0] c);
    return a == AW'(c);
  endfunction

  assign wr_cmd = we && hit(addr, A_CMD);
  assign merged = (cmd_q & RO_MASK) | (wdata & ~RO_MASK);

  assign eng_en    = {merged[CMD_RXEN], merged[CMD_START]};
  assign eng_run_q = {cmd_q[CMD_RXRUN], cmd_q[CMD_LRUN]};
  assign eng_ok    = {rx_ok, list_ok};

  for (genvar g = 0; g < N_ENG; g++) begin : g_eng
    hport_eng_ctl u_eng (
      .en(eng_en[g]), .run_q(eng_run_q[g]), .addr_ok(eng_ok[g]),
      .run_d(eng_run_d[g]), .fail(eng_fail[g])
    );
  end

  always_comb begin
    cmd_w = merged;
    cmd_w[CMD_LRUN]  = eng_run_d[0];
    cmd_w[CMD_RXRUN] = eng_run_d[1];
  end

  hport_irq #(.DW(DW), .IE_MASK(IE_MASK)) u_irq (
    .clk(clk), .rst(rst),
    .wr_is(we && hit(addr, A_ISR)), .wr_ie(we && hit(addr, A_IEN)),
    .clr_all(prst_now), .wdata(wdata), .hw_set(irq_set),
    .is_q(is_q), .ie_q(ie_q), .irq(irq)
  );

  hport_link #(.DW(DW), .DET_W(DET_W)) u_link (
    .clk(clk), .rst(rst),
    .wr_ctl(we && hit(addr, A_LCT)), .wr_err(we && hit(addr, A_LER)),
    .wr_act(we && hit(addr, A_LAC)), .wr_iss(we && hit(addr, A_ISS)),
    .wdata(wdata), .err_set(lerr_set),
    .ctl_q(ctl_q), .err_q(err_q), .act_q(act_q), .iss_q(ci_q),
    .prst_now(prst_now), .port_rst(port_rst), .iss_stb(issue_stb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lbl_q <= '0; lbh_q <= '0; rbl_q <= '0; rbh_q <= '0;
      cmd_q <= '0; sent_q <= 1'b0; init_req <= 1'b0; eng_err <= 1'b0;
    end else begin
      if (we && hit(addr, A_LBL)) lbl_q <= wdata;
      if (we && hit(addr, A_LBH)) lbh_q <= wdata;
      if (we && hit(addr, A_RBL)) rbl_q <= wdata;
      if (we && hit(addr, A_RBH)) rbh_q <= wdata;
      eng_err  <= wr_cmd && (|eng_fail);
      init_req <= wr_cmd && eng_run_d[1] && !sent_q;
      if (wr_cmd && eng_run_d[1]) sent_q <= 1'b1;
      if (prst_now)    cmd_q <= cmd_q & ~RO_MASK;
      else if (wr_cmd) cmd_q <= cmd_w;
    end
  end

  always_comb begin
    rd_mux = '0;
    if      (hit(addr, A_LBL)) rd_mux = lbl_q;
    else if (hit(addr, A_LBH)) rd_mux = lbh_q;
    else if (hit(addr, A_RBL)) rd_mux = rbl_q;
    else if (hit(addr, A_RBH)) rd_mux = rbh_q;
    else if (hit(addr, A_ISR)) rd_mux = is_q;
    else if (hit(addr, A_IEN)) rd_mux = ie_q;
    else if (hit(addr, A_CMD)) rd_mux = cmd_q;
    else if (hit(addr, A_TFD)) rd_mux = tfd_in;
    else if (hit(addr, A_SIG)) rd_mux = sig_in;
    else if (hit(addr, A_LST)) rd_mux = ssts_in;
    else if (hit(addr, A_LCT)) rd_mux = ctl_q;
    else if (hit(addr, A_LER)) rd_mux = err_q;
    else if (hit(addr, A_LAC)) rd_mux = act_q;
    else if (hit(addr, A_ISS)) rd_mux = ci_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/hport_csr_chk.sv
module hport_csr_chk
  import hport_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input logic          clk,
  input logic          rst,
  input logic          we,
  input logic [AW-1:0] addr,
  input logic          list_ok,
  input logic          rx_ok,
  input logic          port_rst,
  input logic          init_req,
  input logic          issue_stb,
  input logic          eng_err,
  input logic [DW-1:0] cmd_q,
  input logic [DW-1:0] ci_q
);
  logic [1:0] n_init;
  always_ff @(posedge clk) begin
    if (rst) n_init <= '0;
    else if (init_req && n_init != 2'd3) n_init <= n_init + 2'd1;
  end

  // R8: the initial status request fires at most once per reset
  a_r8_single_init: assert property (@(posedge clk) disable iff (rst) n_init <= 2'd1);

  // R6: list running only rises when its address was valid
  a_r6_list_needs_ok: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_q[CMD_LRUN]) |-> $past(list_ok));

  // R7: receive running only rises when its address was valid
  a_r7_rx_needs_ok: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_q[CMD_RXRUN]) |-> $past(rx_ok));

  // R6: a refused start follows a command write with an invalid address
  a_r6_err_cause: assert property (@(posedge clk) disable iff (rst)
    eng_err |-> ($past(we && addr == AW'(A_CMD)) && ($past(!list_ok) || $past(!rx_ok))));

  // R9: port reset is a single-cycle pulse that leaves issue empty
  a_r9_rst_pulse: assert property (@(posedge clk) disable iff (rst)
    port_rst |=> !port_rst);
  a_r9_rst_clears: assert property (@(posedge clk) disable iff (rst)
    port_rst |-> (ci_q == '0 && !cmd_q[CMD_LRUN] && !cmd_q[CMD_RXRUN]));

  // R10: issue bits only accumulate outside port reset, and the strobe follows a write
  a_r10_issue_grows: assert property (@(posedge clk) disable iff (rst)
    !port_rst |-> ((ci_q & $past(ci_q)) == $past(ci_q)));
  a_r10_strobe_cause: assert property (@(posedge clk) disable iff (rst)
    issue_stb |-> $past(we && addr == AW'(A_ISS)));
endmodule

bind hport_csr hport_csr_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .we(we), .addr(addr), .list_ok(list_ok), .rx_ok(rx_ok),
  .port_rst(port_rst), .init_req(init_req), .issue_stb(issue_stb),
  .eng_err(eng_err), .cmd_q(cmd_q), .ci_q(ci_q)
);

// File: tb/hport_csr_bench.sv
module hport_csr_bench;
  import hport_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, we = 1'b0, list_ok = 1'b0, rx_ok = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, irq_set = '0, lerr_set = '0;
  logic [31:0] tfd_in = 32'h0000_0050, sig_in = 32'h0000_0101, ssts_in = 32'h0000_0113;
  logic [31:0] rdata;
  logic irq, port_rst, init_req, issue_stb, eng_err;
  int n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hport_csr u_hport_csr (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .we(we), .rdata(rdata),
    .list_ok(list_ok), .rx_ok(rx_ok), .irq_set(irq_set), .lerr_set(lerr_set),
    .tfd_in(tfd_in), .sig_in(sig_in), .ssts_in(ssts_in), .irq(irq),
    .port_rst(port_rst), .init_req(init_req), .issue_stb(issue_stb), .eng_err(eng_err)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(posedge clk); @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; we = 1'b0;
    @(posedge clk); @(negedge clk); v = rdata;
  endtask

  task automatic hw_pulse(input logic [31:0] i, input logic [31:0] e);
    @(negedge clk); irq_set = i; lerr_set = e;
    @(posedge clk); @(negedge clk); irq_set = '0; lerr_set = '0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_CMD, v); check("R1 cmd", v, 0);
    rd(A_ISR, v); check("R1 is", v, 0);
    rd(A_ISS, v); check("R1 ci", v, 0);
    check("R1 outs", {27'd0, irq, port_rst, init_req, issue_stb, eng_err}, 0);
  endtask

  task automatic t_bases;
    logic [31:0] v;
    wr(A_LBL, 32'hDEAD_BEE0); wr(A_LBH, 32'h1234_5678);
    wr(A_RBL, 32'hCAFE_F000); wr(A_RBH, 32'h0BAD_0001);
    rd(A_LBL, v); check("R2 lbl", v, 32'hDEAD_BEE0);
    rd(A_LBH, v); check("R2 lbh", v, 32'h1234_5678);
    rd(A_RBL, v); check("R2 rbl", v, 32'hCAFE_F000);
    rd(A_RBH, v); check("R2 rbh", v, 32'h0BAD_0001);
    // R12: read during a write of the same word returns the old value
    wr(A_LBL, 32'h0000_1111); check("R12 old", rdata, 32'hDEAD_BEE0);
    rd(A_LBL, v); check("R12 new", v, 32'h0000_1111);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    hw_pulse(32'h11, 0);
    rd(A_ISR, v); check("R3 set", v, 32'h11);
    wr(A_ISR, 32'h01);
    rd(A_ISR, v); check("R3 w1c", v, 32'h10);
    irq_set = 32'h10; wr(A_ISR, 32'h10); irq_set = '0;
    rd(A_ISR, v); check("R3 set wins", v, 32'h10);
    check("R4 irq off", {31'd0, irq}, 0);
    wr(A_IEN, 32'hFFFF_FFFF); check("R4 irq on", {31'd0, irq}, 1);
    rd(A_IEN, v); check("R4 mask", v, 32'hFDC0_00FF);
    wr(A_IEN, 32'h0); check("R4 irq off again", {31'd0, irq}, 0);
    wr(A_ISR, 32'hFFFF_FFFF);
    rd(A_ISR, v); check("R3 all clr", v, 0);
  endtask

  task automatic t_cmd;
    logic [31:0] v;
    list_ok = 1'b1; rx_ok = 1'b1;
    wr(A_CMD, 32'h0000_C000);
    rd(A_CMD, v); check("R5 ro bits", v, 0);
    wr(A_CMD, 32'h0000_0F00);
    rd(A_CMD, v); check("R5 rw bits", v, 32'h0000_0F00);
    list_ok = 1'b0;
    wr(A_CMD, 32'h1); check("R6 err", {31'd0, eng_err}, 1);
    rd(A_CMD, v); check("R6 no run", v, 32'h1);
    list_ok = 1'b1;
    wr(A_CMD, 32'h1); check("R6 no err", {31'd0, eng_err}, 0);
    rd(A_CMD, v); check("R6 run", v, 32'h8001);
    wr(A_CMD, 32'h0);
    rd(A_CMD, v); check("R6 stop", v, 0);
  endtask

  task automatic t_rx;
    logic [31:0] v;
    rx_ok = 1'b0;
    wr(A_CMD, 32'h10);
    check("R7 err", {31'd0, eng_err}, 1);
    check("R8 no req on fail", {31'd0, init_req}, 0);
    rd(A_CMD, v); check("R7 no run", v, 32'h10);
    rx_ok = 1'b1;
    wr(A_CMD, 32'h10); check("R8 first req", {31'd0, init_req}, 1);
    rd(A_CMD, v); check("R7 run", v, 32'h4010);
    wr(A_CMD, 32'h0);
    rd(A_CMD, v); check("R7 stop", v, 0);
    wr(A_CMD, 32'h10); check("R8 no second req", {31'd0, init_req}, 0);
    rd(A_CMD, v); check("R7 rerun", v, 32'h4010);
  endtask

  task automatic t_link_reset;
    logic [31:0] v;
    wr(A_ISS, 32'h5); wr(A_LAC, 32'h3); hw_pulse(32'h4, 32'h8);
    wr(A_CMD, 32'h11);
    wr(A_LCT, 32'h2); wr(A_LCT, 32'h0);
    check("R9 det2 no rst", {31'd0, port_rst}, 0);
    rd(A_ISS, v); check("R9 det2 keeps ci", v, 32'h5);
    wr(A_LCT, 32'h1); check("R9 no rst on set", {31'd0, port_rst}, 0);
    wr(A_LCT, 32'h300); check("R9 rst pulse", {31'd0, port_rst}, 1);
    rd(A_ISS, v); check("R9 ci clr", v, 0);
    rd(A_LAC, v); check("R9 act clr", v, 0);
    rd(A_ISR, v); check("R9 is clr", v, 0);
    rd(A_LER, v); check("R9 err clr", v, 0);
    rd(A_CMD, v); check("R9 cmd runs clr", v, 32'h11);
    rd(A_LCT, v); check("R9 ctl stored", v, 32'h300);
  endtask

  task automatic t_link_regs;
    logic [31:0] v;
    hw_pulse(0, 32'h0F);
    wr(A_LER, 32'h05);
    rd(A_LER, v); check("R10 err w1c", v, 32'h0A);
    wr(A_LAC, 32'h1); wr(A_LAC, 32'h2);
    rd(A_LAC, v); check("R10 act w1s", v, 32'h3);
    wr(A_ISS, 32'h4); check("R10 strobe", {31'd0, issue_stb}, 1);
    wr(A_ISS, 32'h1);
    rd(A_ISS, v); check("R10 ci w1s", v, 32'h5);
    check("R10 strobe drop", {31'd0, issue_stb}, 0);
  endtask

  task automatic t_readonly;
    logic [31:0] v;
    wr(A_TFD, 32'hFFFF_FFFF); wr(A_SIG, 32'hFFFF_FFFF); wr(A_LST, 32'hFFFF_FFFF);
    rd(A_TFD, v); check("R11 tfd", v, 32'h50);
    rd(A_SIG, v); check("R11 sig", v, 32'h101);
    rd(A_LST, v); check("R11 ssts", v, 32'h113);
    wr(6'h1C, 32'hFFFF_FFFF);
    rd(6'h1C, v); check("R11 hole", v, 0);
    rd(6'h3C, v); check("R11 top hole", v, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog got=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset;
    t_bases;
    t_irq;
    t_cmd;
    t_rx;
    t_link_reset;
    t_link_regs;
    t_readonly;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule